// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Pin Override and Break

The block sends bytes on one asynchronous serial line: a 0 start bit, the data bits least significant bit first, and a 1 stop bit. Each bit lasts sixteen pulses of a 16x baud tick input. A byte is offered on a valid/ready handshake. The transmitter takes a byte only when it is enabled and idle.

The serial pin is shared with a two-bit port control. While the transmit-enable input is low, the pin's output-enable follows the port direction bit and its level follows the port level bit. Software therefore starts with both bits high so the line rests at mark. Dropping transmit-enable resets the transmitter on the next clock edge, even in the middle of a frame. To send a break, software first drives the port level bit low and then drops transmit-enable. The line then stays low for as long as that condition is held. Raising transmit-enable again leaves the transmitter idle at mark, and the aborted frame is discarded.

Top module: `uart_brk_tx`

## Requirements
- R1: While tx_en is 0, pin_oe equals port_oe and pin_out equals port_lvl. With port_oe at 0 the pin is released (pin_oe = 0).
- R2: While tx_en is 1, pin_oe is 1 and pin_out comes from the transmitter. port_oe and port_lvl have no effect.
- R3: An enabled transmitter with no frame in progress holds pin_out at 1 and busy at 0.
- R4: A frame is a start bit of 0, then wr_data[0] through wr_data[7] in that order, then one stop bit of 1.
- R5: Every bit of a frame lasts exactly 16 tick16 pulses, counted from the clock edge that accepts the byte.
- R6: wr_ready equals tx_en AND NOT busy. A byte is taken only on an edge where wr_valid and wr_ready are both 1. Writes offered while busy or disabled leave the line and the frame unchanged.
- R7: busy rises on the accepting edge and stays 1 until the end of the 160th tick of the frame, when it returns to 0.
- R8: On the first clock edge that samples tx_en at 0, busy goes to 0 and any frame in progress is abandoned.
- R9: After an abort, re-enabling leaves the transmitter idle at mark (pin_out = 1, busy = 0). No part of the aborted frame is sent.
- R10: Setting port_lvl to 0 and then clearing tx_en mid-frame drives pin_out to 0 with pin_oe at 1, for as long as that state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_en | input | 1 | Transmit enable; low resets the transmitter and hands the pin to the port bits |
| port_oe | input | 1 | Port direction bit used while disabled (1 = drive) |
| port_lvl | input | 1 | Port level bit used while disabled |
| wr_valid | input | 1 | Byte offered |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Transmitter can take a byte this cycle |
| busy | output | 1 | A frame is in progress |
| pin_out | output | 1 | Serial pin level |
| pin_oe | output | 1 | Serial pin output-enable |

## Verification
The assertions assume that tick16 is a single-cycle pulse and that wr_valid and wr_data are steady around the sampling edge. They also assume that tx_en is changed only by the surrounding logic, with no glitching within a cycle. The stimulus drives every input on the falling clock edge. It spaces tick pulses 2 to 4 cycles apart, with a period drawn from a seeded generator for each frame. No tick therefore falls on the cycle after a counted tick, and the bench can use that cycle for a rejected write without losing count of ticks. Port bits are randomised during frames to show they have no effect, and aborts are placed at directed points inside a frame.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // True when a sub-bit counter sits on its final count.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

  // Line level sent while idle.
  localparam logic MARK = 1'b1;

endpackage

// File: rtl/uart_brk_baud.sv
module uart_brk_baud #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick16,
  output logic bit_end
);
  import uart_brk_pkg::*;

  localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

  logic [CW-1:0] sub_q;

  assign bit_end = run && tick16 && at_limit(int'(sub_q), OVERSAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (clr || !run) begin
      sub_q <= '0;
    end else if (tick16) begin
      if (bit_end) sub_q <= '0;
      else         sub_q <= sub_q + 1'b1;
    end
  end

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STOP_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              bit_end,
  output logic              busy,
  output logic              line,
  output logic              last_bit
);
  import uart_brk_pkg::*;

  localparam int unsigned FRAME_LEN = 1 + DATA_W + STOP_BITS;
  localparam int unsigned IW        = $clog2(FRAME_LEN);

  tx_state_e             st_q;
  logic [FRAME_LEN-1:0]  sh_q;
  logic [IW-1:0]         idx_q;

  assign busy     = (st_q == ST_SEND);
  assign line     = busy ? sh_q[0] : MARK;
  assign last_bit = busy && at_limit(int'(idx_q), FRAME_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
    end else if (flush) begin
      st_q  <= ST_IDLE;
      sh_q  <= '1;
      idx_q <= '0;
    end else if (load) begin
      st_q  <= ST_SEND;
      sh_q  <= {{STOP_BITS{1'b1}}, data, 1'b0};
      idx_q <= '0;
    end else if (bit_end) begin
      sh_q  <= {1'b1, sh_q[FRAME_LEN-1:1]};
      if (last_bit) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_brk_pinmux.sv
module uart_brk_pinmux (
  input  logic tx_en,
  input  logic line,
  input  logic port_oe,
  input  logic port_lvl,
  output logic pin_out,
  output logic pin_oe
);
  always_comb begin
    if (tx_en) begin
      pin_oe  = 1'b1;
      pin_out = line;
    end else begin
      pin_oe  = port_oe;
      pin_out = port_lvl;
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned STOP_BITS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              tx_en,
  input  logic              port_oe,
  input  logic              port_lvl,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              busy,
  output logic              pin_out,
  output logic              pin_oe
);

  logic accept;
  logic bit_end;
  logic last_bit;
  logic line;
  logic flush;

  assign flush    = !tx_en;
  assign wr_ready = tx_en && !busy;
  assign accept   = wr_valid && wr_ready;

  uart_brk_baud #(.OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept || flush),
    .run     (busy),
    .tick16  (tick16),
    .bit_end (bit_end)
  );

  uart_brk_shift #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (accept),
    .data     (wr_data),
    .bit_end  (bit_end),
    .busy     (busy),
    .line     (line),
    .last_bit (last_bit)
  );

  uart_brk_pinmux u_mux (
    .tx_en    (tx_en),
    .line     (line),
    .port_oe  (port_oe),
    .port_lvl (port_lvl),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic tx_en,
  input logic wr_valid,
  input logic busy,
  input logic pin_out,
  input logic pin_oe,
  input logic bit_end,
  input logic last_bit
);

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy);

  // R6
  accept_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_valid && tx_en));

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && tx_en) |-> !pin_out);

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_en && !tick16) |=> busy);

  // R5
  end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && last_bit && tx_en) |=> !busy);

  // R3
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !busy) |-> (pin_out && pin_oe));

  // R2
  enabled_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> pin_oe);

endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick16   (tick16),
  .tx_en    (tx_en),
  .wr_valid (wr_valid),
  .busy     (busy),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .bit_end  (bit_end),
  .last_bit (last_bit)
);

// File: tb/sim_uart_brk_tx.sv
module sim_uart_brk_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       tx_en = 1'b0;
  logic       port_oe = 1'b1;
  logic       port_lvl = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, busy, pin_out, pin_oe;

  int total = 0;
  int bad = 0;
  int tper = 2;
  int tcnt = 0;

  always #2 clk = ~clk;

  uart_brk_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_en(tx_en),
    .port_oe(port_oe), .port_lvl(port_lvl), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always @(negedge clk) begin
    if (tcnt >= tper - 1) begin
      tick16 <= 1'b1;
      tcnt   <= 0;
    end else begin
      tick16 <= 1'b0;
      tcnt   <= tcnt + 1;
    end
  end

  // Expected level of bit b of a frame carrying d.
  function automatic logic exp_bit(input logic [7:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b >= 9) return 1'b1;
    return d[b-1];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    int i = 0;
    while (i < n) begin
      @(posedge clk);
      if (tick16) i++;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit poke_busy);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    chk("R6 ready when idle", wr_ready, 1);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R7 busy after accept", busy, 1);
    chk("R4 start level", pin_out, 0);
    for (int b = 0; b < 10; b++) begin
      wait_ticks(8);
      @(negedge clk);
      port_oe  = $urandom_range(0, 1);
      port_lvl = $urandom_range(0, 1);
      chk("R4 bit level", pin_out, exp_bit(d, b));
      chk("R2 oe forced", pin_oe, 1);
      if (poke_busy && b == 3) begin
        wr_valid = 1'b1;
        wr_data  = ~d;
        chk("R6 not ready while busy", wr_ready, 0);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
      end
      if (b < 9) begin
        wait_ticks(8);
      end else begin
        wait_ticks(7);
        @(negedge clk);
        chk("R7 busy through stop", busy, 1);
        wait_ticks(1);
        @(negedge clk);
        chk("R5 frame is 160 ticks", busy, 0);
        chk("R3 idle mark", pin_out, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state: port bits own the pin
    chk("R1 reset oe", pin_oe, 1);
    chk("R1 reset level", pin_out, 1);
    chk("R7 reset busy", busy, 0);
    chk("R6 reset ready", wr_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    port_oe = 1'b0;
    port_lvl = 1'b0;
    @(negedge clk);
    chk("R1 released pin", pin_oe, 0);
    chk("R1 level follows port", pin_out, 0);
    port_oe = 1'b1;
    port_lvl = 1'b1;
    // R6 write while disabled is dropped
    wr_valid = 1'b1;
    wr_data = 8'h3C;
    @(negedge clk);
    chk("R6 not ready while disabled", wr_ready, 0);
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
    tx_en = 1'b1;
    @(negedge clk);
    chk("R6 disabled write dropped", busy, 0);
    chk("R3 enabled idle", pin_out, 1);

    // directed corner bytes
    send_frame(8'h00, 1'b0);
    send_frame(8'hFF, 1'b1);
    send_frame(8'h01, 1'b0);
    send_frame(8'h80, 1'b0);
    // random bytes and tick spacing
    for (int k = 0; k < 16; k++) begin
      tper = $urandom_range(2, 4);
      send_frame(8'($urandom), (k % 3) == 0);
    end

    // R10 break mid-frame, R8 abort
    tper = 2;
    port_oe = 1'b1;
    port_lvl = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    wait_ticks(16 * 4 + 5);
    @(negedge clk);
    port_lvl = 1'b0;
    @(negedge clk);
    chk("R2 level ignored while enabled", pin_out, 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R8 busy cleared", busy, 0);
    chk("R10 break low", pin_out, 0);
    chk("R10 break driven", pin_oe, 1);
    repeat (60) @(negedge clk);
    chk("R10 break held", pin_out, 0);
    port_lvl = 1'b1;
    @(negedge clk);
    tx_en = 1'b1;
    for (int j = 0; j < 5; j++) begin
      wait_ticks(16);
      @(negedge clk);
      chk("R9 no resume level", pin_out, 1);
      chk("R9 no resume busy", busy, 0);
    end
    send_frame(8'hA5, 1'b0);

    // abort on the start bit, then a clean frame
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    tx_en = 1'b0;
    @(negedge clk);
    chk("R8 abort at start", busy, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R9 idle after start abort", pin_out, 1);
    send_frame(8'h5A, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule